// File: doc/BRIEF.md
# Programmable-frame UART transmitter

This block turns one character into an asynchronous serial frame on a single output line. A transmit-enable tick, supplied from outside at eight times the bit rate, paces every bit. The frame shape is chosen at run time by four configuration inputs:

- the character length, from one to eight bits
- whether a parity bit is present
- the parity sense, odd or even
- one or two stop bits

A character is handed over through a valid/ready handshake. The block accepts it only while idle, and it reports busy from the clock edge that accepts the character until the last stop bit has run its full length. The configuration is captured together with the character, so it may change freely while a frame is on the wire. The ready output comes back one clock after the tick that ends the final stop bit. A producer that holds valid high therefore gets frames back to back, with a single-clock idle gap between them.

Top module: `ser_frame_tx`

## Requirements
- R1: While reset is asserted and whenever no frame is in progress, `tx_line` is high and `busy` is low.
- R2: Every frame starts with exactly one low start bit, which begins at the clock edge that accepts the character.
- R3: After the start bit come `cfg_len`+1 data bits, least significant bit first. A `cfg_len` of 0 sends one bit and a `cfg_len` of 7 sends eight.
- R4: Bits of `in_data` above the selected length never reach the line and never affect the parity bit.
- R5: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd` at 0 it makes the count of ones in data plus parity even, and with `cfg_par_odd` at 1 it makes that count odd. When `cfg_par_en` is 0, no parity bit is sent.
- R6: A frame ends with one high stop bit, or with two when `cfg_two_stop` is 1.
- R7: Every bit of the frame lasts exactly 8 `tick` pulses. While a frame is in progress, `tx_line` changes only at a clock edge at which `tick` is high.
- R8: `in_ready` is high exactly when `busy` is low. A character is taken only on a clock edge where `in_valid` and `in_ready` are both high. `busy` rises at that edge, and `in_valid` has no effect while `busy` is high.
- R9: The length, parity and stop settings are captured at acceptance. Changing them during a frame does not alter that frame.
- R10: `in_ready` rises at the clock edge that ends the final stop bit. A character offered at that moment is accepted at the next edge, which leaves a one-clock idle gap between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Enable pulse at eight times the bit rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block idle and able to take a character |
| in_data | input | 8 | Character to send, LSB first |
| cfg_len | input | 3 | Character length minus one |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The start bit appears on `tx_line` and `busy` rises at the first clock edge after the one where valid and ready were both seen. From then on, each frame bit holds through eight tick cycles and moves on at the edge that closes its eighth tick. Ready returns at the edge that ends the final stop bit. The bench drives inputs and samples outputs on falling clock edges only. It records the line value once in every tick cycle while busy is high, so a frame of N bits must yield exactly 8N samples, each equal to the expected bit value, and this check covers both the bit values and the bit durations. The back-to-back and ignored-valid cases are checked at the falling edge one and two clocks after the frame ends, which is where ready and the next busy are due.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int DATA_W = 8;
    localparam int LEN_W  = $clog2(DATA_W);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
    } tx_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } tx_state_t;

    function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++)
            m[i] = (i <= int'(len));
        return m;
    endfunction

    function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                       input logic [LEN_W-1:0]  len,
                                       input logic              odd);
        return (^(d & len_mask(len))) ^ odd;
    endfunction

endpackage

// File: rtl/ser_tx_bit_timer.sv
module ser_tx_bit_timer #(
    parameter int TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt;

    assign bit_end = tick && (cnt == CW'(TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick)
            cnt <= bit_end ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/ser_tx_frame_seq.sv
module ser_tx_frame_seq
    import ser_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [DATA_W-1:0] data,
    input  tx_cfg_t           cfg,
    input  logic              bit_end,
    output logic              line,
    output logic              busy
);
    tx_state_t         state;
    tx_cfg_t           cfg_q;
    logic [DATA_W-1:0] shreg;
    logic [LEN_W-1:0]  left;
    logic              par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
            shreg <= '0;
            left  <= '0;
            par_q <= 1'b0;
        end else if (accept) begin
            state <= ST_START;
            cfg_q <= cfg;
            shreg <= data & len_mask(cfg.len);
            par_q <= parity_of(data, cfg.len, cfg.par_odd);
        end else if (bit_end) begin
            case (state)
                ST_START: begin
                    state <= ST_DATA;
                    left  <= cfg_q.len;
                end
                ST_DATA: begin
                    shreg <= shreg >> 1;
                    if (left == '0)
                        state <= cfg_q.par_en ? ST_PAR : ST_STOP1;
                    else
                        left <= left - 1'b1;
                end
                ST_PAR:   state <= ST_STOP1;
                ST_STOP1: state <= cfg_q.two_stop ? ST_STOP2 : ST_IDLE;
                ST_STOP2: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
    import ser_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    output logic              tx_line,
    output logic              busy
);
    logic    accept;
    logic    bit_end;
    tx_cfg_t cfg_in;

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;

    always_comb begin
        cfg_in.len      = cfg_len;
        cfg_in.par_en   = cfg_par_en;
        cfg_in.par_odd  = cfg_par_odd;
        cfg_in.two_stop = cfg_two_stop;
    end

    ser_tx_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .tick    (tick),
        .bit_end (bit_end)
    );

    ser_tx_frame_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .data    (in_data),
        .cfg     (cfg_in),
        .bit_end (bit_end),
        .line    (tx_line),
        .busy    (busy)
    );
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic tx_line
);
    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_line);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx_line);

    // R7
    hold_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(tx_line));

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy);

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready != busy);
endmodule

bind ser_frame_tx ser_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .tx_line  (tx_line)
);

// File: tb/test_ser_frame_tx.sv
module test_ser_frame_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic [2:0] cfg_len = 3'd7;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       tx_line;
    logic       busy;

    int total = 0;
    int bad = 0;
    logic exp_bits [0:15];
    int   exp_n;
    logic rec [0:127];
    int   rec_n;
    logic [1:0] tdiv = 2'd0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd2);
    end

    ser_frame_tx i_ser_frame_tx (
        .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .tx_line(tx_line), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d exp %0d", tag, what, got, exp);
        end
    endtask

    task automatic build_exp(input logic [7:0] d, input logic [2:0] l,
                             input logic pe, input logic po, input logic ts);
        logic p;
        p = 1'b0;
        exp_n = 0;
        exp_bits[exp_n++] = 1'b0;
        for (int i = 0; i <= int'(l); i++) begin
            exp_bits[exp_n++] = d[i];
            p ^= d[i];
        end
        if (pe) exp_bits[exp_n++] = p ^ po;
        exp_bits[exp_n++] = 1'b1;
        if (ts) exp_bits[exp_n++] = 1'b1;
    endtask

    // called on a falling edge where the frame is expected to be running
    task automatic record_frame();
        rec_n = 0;
        while (busy && rec_n < 128) begin
            if (tick) rec[rec_n++] = tx_line;
            @(negedge clk);
        end
    endtask

    task automatic compare(input string tag);
        int errs = 0;
        int first = -1;
        check(rec_n == exp_n * 8, tag, "tick samples in frame", rec_n, exp_n * 8);
        for (int k = 0; k < rec_n; k++) begin
            if (k / 8 < exp_n && rec[k] !== exp_bits[k / 8]) begin
                errs++;
                if (first < 0) first = k;
            end
        end
        check(errs == 0, tag, "mismatching samples (first index shown as exp)",
              errs, first);
        check(tx_line === 1'b1 && busy === 1'b0, tag, "idle after frame",
              int'(tx_line), 1);
    endtask

    task automatic offer(input logic [7:0] d, input logic [2:0] l,
                         input logic pe, input logic po, input logic ts);
        @(negedge clk);
        in_data = d; cfg_len = l; cfg_par_en = pe;
        cfg_par_odd = po; cfg_two_stop = ts;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send(input string tag, input logic [7:0] d, input logic [2:0] l,
                        input logic pe, input logic po, input logic ts);
        build_exp(d, l, pe, po, ts);
        offer(d, l, pe, po, ts);
        check(busy === 1'b1, tag, "busy after accept", int'(busy), 1);
        record_frame();
        compare(tag);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        // R1
        check(tx_line === 1'b1, "R1", "line during reset", int'(tx_line), 1);
        check(busy === 1'b0, "R1", "busy during reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line === 1'b1 && in_ready === 1'b1, "R1", "idle after reset",
              int'(tx_line), 1);
    endtask

    task automatic t_cfg_change();
        // R9: settings switched right after acceptance
        build_exp(8'h6C, 3'd7, 1'b0, 1'b0, 1'b0);
        offer(8'h6C, 3'd7, 1'b0, 1'b0, 1'b0);
        cfg_len = 3'd1; cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1;
        record_frame();
        compare("R9");
    endtask

    task automatic t_valid_busy();
        // R8: valid offered mid-frame is ignored
        build_exp(8'h3A, 3'd7, 1'b0, 1'b0, 1'b0);
        offer(8'h3A, 3'd7, 1'b0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        check(in_ready === 1'b0, "R8", "ready while busy", int'(in_ready), 0);
        in_data = 8'h00;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rec_n = 0;
        record_frame();
        check(rec_n > 0 && tx_line === 1'b1, "R8", "frame completed", rec_n, 1);
        repeat (6) @(negedge clk);
        check(busy === 1'b0, "R8", "no frame started by mid-frame valid",
              int'(busy), 0);
    endtask

    task automatic t_back_to_back();
        // R10
        build_exp(8'hC3, 3'd3, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        in_data = 8'hC3; cfg_len = 3'd3; cfg_par_en = 1'b1;
        cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        in_data = 8'h0E; cfg_len = 3'd4; cfg_par_en = 1'b0; cfg_two_stop = 1'b1;
        record_frame();
        compare("R10");
        check(in_ready === 1'b1, "R10", "ready one clock after last stop tick",
              int'(in_ready), 1);
        @(negedge clk);
        check(busy === 1'b1, "R10", "second frame taken after one idle clock",
              int'(busy), 1);
        in_valid = 1'b0;
        build_exp(8'h0E, 3'd4, 1'b0, 1'b0, 1'b1);
        record_frame();
        compare("R10");
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog: got 0 exp 1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        send("R2_R3_R7", 8'hA5, 3'd7, 1'b0, 1'b0, 1'b0);
        send("R5_even", 8'h13, 3'd4, 1'b1, 1'b0, 1'b0);
        send("R5_R6_odd", 8'h55, 3'd6, 1'b1, 1'b1, 1'b1);
        send("R3_single", 8'hFE, 3'd0, 1'b0, 1'b0, 1'b0);
        send("R4", 8'hF8, 3'd2, 1'b1, 1'b0, 1'b0);
        send("R6_two", 8'h81, 3'd7, 1'b0, 1'b0, 1'b1);
        t_cfg_change();
        t_valid_busy();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule